// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block is a single-channel copy engine steered by an eight-word transfer descriptor. On a start pulse it reads the descriptor from memory into local registers, checks it, and then copies data through a 32-bit read/write memory port. Each descriptor defines an element size, a number of bytes per inner loop, a signed step for the source and destination addresses after every element, and an outer iteration count. When the outer count runs out, the engine either adds the final adjustments to both addresses and reports completion, or it follows a link pointer to the next descriptor and runs that one next.

Elements of 16 or 32 bytes are moved as consecutive 4-byte beats. Each beat is read and then written before the next beat starts. Interrupt pulses can be requested at the halfway point of the outer loop and at its end. A descriptor that cannot be run, or an error response from memory, stops the engine and leaves a reason code. Channel linking, bandwidth throttling and address wrap-around are not implemented. The descriptor bits that would select them are ignored.

Top module: `sgx_engine`

## Requirements
- R1: After reset, busy, done, irq and mem_req are 0 and err_code is 0.
- R2: A start pulse while idle reads eight 32-bit words at desc_addr, desc_addr+4, ..., desc_addr+28. Word 0 is the source address. Word 1 holds the source size code in [26:24], the destination size code in [18:16] and the signed source step in [15:0]. Word 2 is the inner byte count. Word 3 is the final source adjustment. Word 4 is the destination address. Word 5 holds the current outer count in [24:16] and the signed destination step in [15:0]. Word 6 is the final destination adjustment or the link pointer. Word 7 holds the outer reload count in [31:23], link-enable in [11], halfway-interrupt enable in [9] and end-interrupt enable in [8]. Bits [31:27] and [23:19] of word 1 are ignored.
- R3: Size codes 0, 1, 2, 4 and 5 mean elements of 1, 2, 4, 16 and 32 bytes. An element is moved as beats of min(size,4) bytes at consecutive addresses, and mem_bytes gives the beat width (1, 2 or 4). Read data is right-aligned.
- R4: After every element, the source and destination addresses advance by their sign-extended 16-bit steps. Negative steps move downward.
- R5: One inner loop moves byte-count/size elements. The outer count decrements once per inner loop, and the run ends after that many inner loops.
- R6: When link-enable is 0, the final adjustments are added to both addresses at the end of the run. src_addr and dst_addr then show the result.
- R7: When link-enable is 1, the end of the outer loop fetches the next descriptor from the word-6 pointer and runs it. No final adjustment is applied.
- R8: At the end of the outer loop, irq pulses for one cycle if end-interrupt is enabled.
- R9: If halfway-interrupt is enabled, irq pulses after the inner loop in which the decremented count equals reload/2. This applies only while that count is nonzero.
- R10: done is set and busy cleared in the same cycle at the end of a run without a link. A start clears done.
- R11: A descriptor with a zero byte count, a zero outer count, an unknown size code, unequal source and destination codes, or a byte count that is not a multiple of the size moves no data. It ends with err_code 1.
- R12: An error response aborts the run with no further memory request and done left 0. err_code is 2 for a data read, 3 for a data write and 4 for a descriptor read.
- R13: A start pulse while busy is ignored.
- R14: mem_req, mem_addr, mem_we and mem_bytes hold steady until mem_ack or mem_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin fetching a descriptor at desc_addr |
| desc_addr | input | 32 | Address of the first descriptor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_bytes | output | 3 | Beat width in bytes (1, 2, 4) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed |
| busy | output | 1 | Descriptor fetch or transfer in progress |
| done | output | 1 | Last run completed normally |
| irq | output | 1 | One-cycle interrupt pulse |
| err_code | output | 3 | Abort reason, 0 when none |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
Two events can fall in the same cycle. When a linked descriptor that requests an end interrupt finishes its outer loop, the interrupt pulse and the start of the next descriptor fetch are produced together. The bench provokes this by chaining two descriptors that both enable the end interrupt. It then judges that exactly two pulses are seen, that the memory image matches a bench-side model of both copies, and that the final addresses are those of the second descriptor with its adjustments added.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int MAJ_W      = 9;
  localparam int OFF_W      = 16;
  localparam int EB_W       = 6;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_CFG       = 3'd1,
    ERR_SRC_BUS   = 3'd2,
    ERR_DST_BUS   = 3'd3,
    ERR_FETCH_BUS = 3'd4
  } sgx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_LOOP
  } sgx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] saddr;
    logic [2:0]        ssize;
    logic [2:0]        dsize;
    logic [OFF_W-1:0]  soff;
    logic [WORD_W-1:0] nbytes;
    logic [WORD_W-1:0] slast;
    logic [WORD_W-1:0] daddr;
    logic [MAJ_W-1:0]  citer;
    logic [OFF_W-1:0]  doff;
    logic [WORD_W-1:0] dlast_link;
    logic [MAJ_W-1:0]  biter;
    logic              link_en;
    logic              half_irq_en;
    logic              end_irq_en;
  } sgx_desc_t;

  function automatic logic size_code_ok(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic [EB_W-1:0] elem_bytes(input logic [2:0] c);
    case (c)
      3'd0:    return EB_W'(1);
      3'd1:    return EB_W'(2);
      3'd2:    return EB_W'(4);
      3'd4:    return EB_W'(16);
      3'd5:    return EB_W'(32);
      default: return '0;
    endcase
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [EB_W-1:0] eb);
    return (eb >= EB_W'(4)) ? 3'd4 : eb[2:0];
  endfunction

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                  input logic [OFF_W-1:0] off);
    return a + {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction
endpackage

// File: rtl/sgx_desc_fields.sv
module sgx_desc_fields
  import sgx_pkg::*;
(
  input  logic [DESC_WORDS*WORD_W-1:0] words_i,
  output sgx_desc_t                    desc_o,
  output logic                         cfg_bad_o
);
  logic [WORD_W-1:0] w [DESC_WORDS];
  logic [EB_W-1:0]   eb;
  logic              unused_bits;

  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_unpack
    assign w[k] = words_i[k*WORD_W +: WORD_W];
  end

  always_comb begin
    desc_o.saddr       = w[0];
    desc_o.ssize       = w[1][26:24];
    desc_o.dsize       = w[1][18:16];
    desc_o.soff        = w[1][15:0];
    desc_o.nbytes      = w[2];
    desc_o.slast       = w[3];
    desc_o.daddr       = w[4];
    desc_o.citer       = w[5][24:16];
    desc_o.doff        = w[5][15:0];
    desc_o.dlast_link  = w[6];
    desc_o.biter       = w[7][31:23];
    desc_o.link_en     = w[7][11];
    desc_o.half_irq_en = w[7][9];
    desc_o.end_irq_en  = w[7][8];
  end

  assign eb = elem_bytes(desc_o.ssize);

  assign cfg_bad_o = !size_code_ok(desc_o.ssize)
                  || (desc_o.ssize != desc_o.dsize)
                  || (desc_o.nbytes == '0)
                  || (desc_o.citer == '0)
                  || ((desc_o.nbytes & (WORD_W'(eb) - WORD_W'(1))) != '0);

  assign unused_bits = ^{w[1][31:27], w[1][23:19], w[5][31:25], w[7][22:12], w[7][10], w[7][7:0]};
endmodule

// File: rtl/sgx_loop_count.sv
module sgx_loop_count
  import sgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] nbytes_i,
  input  logic [MAJ_W-1:0]  citer_i,
  input  logic [MAJ_W-1:0]  biter_i,
  input  logic              elem_done_i,
  input  logic [EB_W-1:0]   elem_bytes_i,
  input  logic              loop_step_i,
  output logic              minor_last_o,
  output logic              major_last_o,
  output logic              half_hit_o
);
  logic [WORD_W-1:0] rem_q;
  logic [MAJ_W-1:0]  cnt_q;
  logic [MAJ_W-1:0]  cnt_nxt;

  assign cnt_nxt      = cnt_q - MAJ_W'(1);
  assign minor_last_o = (rem_q == WORD_W'(elem_bytes_i));
  assign major_last_o = (cnt_q == MAJ_W'(1));
  assign half_hit_o   = !major_last_o && (cnt_nxt == (biter_i >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      rem_q <= nbytes_i;
      cnt_q <= citer_i;
    end else if (loop_step_i) begin
      rem_q <= nbytes_i;
      cnt_q <= major_last_o ? biter_i : cnt_nxt;
    end else if (elem_done_i) begin
      rem_q <= rem_q - WORD_W'(elem_bytes_i);
    end
  end
endmodule

// File: rtl/sgx_engine.sv
module sgx_engine
  import sgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] desc_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [2:0]        mem_bytes,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [2:0]        err_code,
  output logic [WORD_W-1:0] src_addr,
  output logic [WORD_W-1:0] dst_addr
);
  localparam int FIDX_W = $clog2(DESC_WORDS);

  sgx_state_e                   state_q;
  logic [WORD_W-1:0]            dw_q [DESC_WORDS];
  logic [DESC_WORDS*WORD_W-1:0] dw_flat;
  logic [FIDX_W-1:0]            fidx_q;
  logic [WORD_W-1:0]            fetch_base_q, src_q, dst_q, data_q;
  logic [EB_W-1:0]              boff_q;
  sgx_err_e                     err_q;
  logic                         done_q, irq_q;

  sgx_desc_t       d;
  logic            cfg_bad;
  logic [EB_W-1:0] eb;
  logic [2:0]      bw;
  logic            minor_last, major_last, half_hit;

  // named internal events
  logic ev_load, ev_elem_done, ev_loop_step, ev_major_end;

  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_flat
    assign dw_flat[k*WORD_W +: WORD_W] = dw_q[k];
  end

  sgx_desc_fields u_fields (
    .words_i   (dw_flat),
    .desc_o    (d),
    .cfg_bad_o (cfg_bad)
  );

  assign eb = elem_bytes(d.ssize);
  assign bw = beat_bytes(eb);

  assign ev_load      = (state_q == ST_CHECK) && !cfg_bad;
  assign ev_elem_done = (state_q == ST_WRITE) && mem_ack && !mem_err
                        && ((boff_q + EB_W'(bw)) == eb);
  assign ev_loop_step = (state_q == ST_LOOP);
  assign ev_major_end = ev_loop_step && major_last;

  sgx_loop_count u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (ev_load),
    .nbytes_i     (d.nbytes),
    .citer_i      (d.citer),
    .biter_i      (d.biter),
    .elem_done_i  (ev_elem_done),
    .elem_bytes_i (eb),
    .loop_step_i  (ev_loop_step),
    .minor_last_o (minor_last),
    .major_last_o (major_last),
    .half_hit_o   (half_hit)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_bytes = 3'd4;
    mem_wdata = '0;
    case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = fetch_base_q + WORD_W'({fidx_q, 2'b00});
      end
      ST_READ: begin
        mem_req   = 1'b1;
        mem_addr  = src_q + WORD_W'(boff_q);
        mem_bytes = bw;
      end
      ST_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q + WORD_W'(boff_q);
        mem_bytes = bw;
        mem_wdata = data_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      fidx_q       <= '0;
      fetch_base_q <= '0;
      src_q        <= '0;
      dst_q        <= '0;
      data_q       <= '0;
      boff_q       <= '0;
      err_q        <= ERR_NONE;
      done_q       <= 1'b0;
      irq_q        <= 1'b0;
      for (int k = 0; k < DESC_WORDS; k++) dw_q[k] <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          fetch_base_q <= desc_addr;
          fidx_q       <= '0;
          done_q       <= 1'b0;
          err_q        <= ERR_NONE;
          state_q      <= ST_FETCH;
        end
        ST_FETCH: if (mem_err) begin
          err_q   <= ERR_FETCH_BUS;
          state_q <= ST_IDLE;
        end else if (mem_ack) begin
          dw_q[fidx_q] <= mem_rdata;
          if (fidx_q == FIDX_W'(DESC_WORDS - 1)) state_q <= ST_CHECK;
          else fidx_q <= fidx_q + FIDX_W'(1);
        end
        ST_CHECK: if (cfg_bad) begin
          err_q   <= ERR_CFG;
          state_q <= ST_IDLE;
        end else begin
          src_q   <= d.saddr;
          dst_q   <= d.daddr;
          boff_q  <= '0;
          state_q <= ST_READ;
        end
        ST_READ: if (mem_err) begin
          err_q   <= ERR_SRC_BUS;
          state_q <= ST_IDLE;
        end else if (mem_ack) begin
          data_q  <= mem_rdata;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (mem_err) begin
          err_q   <= ERR_DST_BUS;
          state_q <= ST_IDLE;
        end else if (mem_ack) begin
          if (ev_elem_done) begin
            boff_q  <= '0;
            src_q   <= step_addr(src_q, d.soff);
            dst_q   <= step_addr(dst_q, d.doff);
            state_q <= minor_last ? ST_LOOP : ST_READ;
          end else begin
            boff_q  <= boff_q + EB_W'(bw);
            state_q <= ST_READ;
          end
        end
        ST_LOOP: if (major_last) begin
          irq_q <= d.end_irq_en;
          if (d.link_en) begin
            fetch_base_q <= d.dlast_link;
            fidx_q       <= '0;
            state_q      <= ST_FETCH;
          end else begin
            src_q   <= src_q + d.slast;
            dst_q   <= dst_q + d.dlast_link;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end else begin
          irq_q   <= d.half_irq_en && half_hit;
          state_q <= ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign irq      = irq_q;
  assign err_code = err_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;
endmodule

// File: rtl/sgx_engine_checker.sv
module sgx_engine_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        irq,
  input logic [2:0]  err_code,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [2:0]  mem_bytes,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        ev_loop_step
);
  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_bytes)));

  a_r3_beat_width: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_bytes) == 1));

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r10_done_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r12_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0) |-> (!busy && !mem_req));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_irq_from_loop_end: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ev_loop_step));
endmodule

bind sgx_engine sgx_engine_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .irq          (irq),
  .err_code     (err_code),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_bytes    (mem_bytes),
  .mem_ack      (mem_ack),
  .mem_err      (mem_err),
  .ev_loop_step (ev_loop_step)
);

// File: tb/sgx_engine_test.sv
module sgx_engine_test;
  localparam int MEM_SZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start = 1'b0;
  logic [31:0] desc_addr = '0;
  logic        mem_req, mem_we, busy, done, irq;
  logic [31:0] mem_addr, mem_wdata, src_addr, dst_addr;
  logic [2:0]  mem_bytes, err_code;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;

  logic [7:0] mem  [MEM_SZ];
  logic [7:0] refm [MEM_SZ];

  int checks = 0, errors = 0;
  int irq_cnt = 0, xact = 0, hold_viol = 0, lat = 0;
  logic        inj_en = 1'b0, inj_we = 1'b0;
  logic [31:0] inj_addr = '0;
  logic        first_seen = 1'b0;
  logic [31:0] first_req_addr = '0;

  sgx_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .busy(busy), .done(done), .irq(irq), .err_code(err_code),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  always #4 clk = ~clk;

  function automatic int ix(input logic [31:0] a);
    return int'(a[11:0]);
  endfunction

  function automatic int code_len(input logic [2:0] c);
    return (c == 3'd5) ? 32 : (c == 3'd4) ? 16 : (1 << c);
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (irq) irq_cnt++;

  initial begin : responder
    int wait_n;
    logic pend;
    logic [31:0] a_prev;
    wait_n = 0; pend = 1'b0; a_prev = '0;
    forever begin
      @(negedge clk);
      if (mem_ack || mem_err) begin
        mem_ack = 1'b0; mem_err = 1'b0; pend = 1'b0;
      end else if (mem_req) begin
        if (!first_seen) begin first_seen = 1'b1; first_req_addr = mem_addr; end
        if (pend && mem_addr !== a_prev) hold_viol++;
        pend = 1'b1; a_prev = mem_addr;
        if (wait_n < lat) wait_n++;
        else begin
          wait_n = 0;
          xact++;
          if (inj_en && mem_addr == inj_addr && mem_we == inj_we) mem_err = 1'b1;
          else begin
            mem_ack = 1'b1;
            if (mem_we) begin
              for (int b = 0; b < int'(mem_bytes); b++) mem[ix(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
            end else begin
              mem_rdata = '0;
              for (int b = 0; b < int'(mem_bytes); b++) mem_rdata[8*b +: 8] = mem[ix(mem_addr + 32'(b))];
            end
          end
        end
      end
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < MEM_SZ; i++) begin
      mem[i]  = 8'(i * 13 + seed);
      refm[i] = mem[i];
    end
  endtask

  task automatic put_word(input logic [31:0] a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      mem[ix(a + 32'(b))]  = w[8*b +: 8];
      refm[ix(a + 32'(b))] = w[8*b +: 8];
    end
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] sa, input logic [2:0] ssz,
                          input logic [2:0] dsz, input logic [15:0] so, input logic [31:0] nb,
                          input logic [31:0] sl, input logic [31:0] da, input logic [8:0] ci,
                          input logic [15:0] dof, input logic [31:0] dl, input logic [8:0] bi,
                          input bit lnk, input bit hirq, input bit eirq);
    put_word(base,      sa);
    put_word(base + 4,  {5'h1F, ssz, 5'h15, dsz, so});
    put_word(base + 8,  nb);
    put_word(base + 12, sl);
    put_word(base + 16, da);
    put_word(base + 20, {1'b0, 6'd0, ci, dof});
    put_word(base + 24, dl);
    put_word(base + 28, {bi, 2'b00, 6'd0, 1'b0, 1'b0, 1'b0, lnk, 1'b0, hirq, eirq, 1'b1, 7'd0});
  endtask

  // bench restatement of the copy: returns final addresses
  task automatic model(input logic [31:0] sa, input logic [2:0] sz, input logic [15:0] so,
                       input logic [31:0] nb, input logic [31:0] sl, input logic [31:0] da,
                       input int ci, input logic [15:0] dof, input logic [31:0] dl, input bit adj,
                       output logic [31:0] fs, output logic [31:0] fd);
    logic [31:0] s, d;
    int n;
    s = sa; d = da; n = code_len(sz);
    for (int m = 0; m < ci; m++)
      for (int e = 0; e < int'(nb) / n; e++) begin
        for (int b = 0; b < n; b++) refm[ix(d + 32'(b))] = refm[ix(s + 32'(b))];
        s = s + sx(so); d = d + sx(dof);
      end
    if (adj) begin s = s + sl; d = d + dl; end
    fs = s; fd = d;
  endtask

  task automatic cmp_mem(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < MEM_SZ; i++) if (mem[i] !== refm[i]) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  task automatic kick(input logic [31:0] a);
    irq_cnt = 0; xact = 0; first_seen = 1'b0;
    @(negedge clk); desc_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog actual=150000 cycles expected=finish earlier");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] fs, fd, fs2, fd2, sb;
    logic [15:0] so, dof;
    int n;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {24'd0, busy, done, irq, mem_req, 1'b0, err_code}, 32'd0);

    // sweep over size codes, outer counts and step directions
    foreach (sb[i]) ; // no-op keeps sb referenced before use
    for (int ci_sel = 0; ci_sel < 2; ci_sel++)
      for (int dir = 0; dir < 2; dir++)
        for (int cs = 0; cs < 5; cs++) begin
          logic [2:0] code;
          int ci;
          code = (cs < 3) ? 3'(cs) : 3'(cs + 1);
          ci = ci_sel ? 3 : 1;
          n = code_len(code);
          so  = dir ? 16'(-n) : 16'(n);
          dof = dir ? 16'(2 * n) : 16'(n);
          sb  = dir ? 32'h3E0 : 32'h100;
          lat = (cs + dir + ci_sel) % 3;
          fill(cs * 5 + dir + ci_sel * 11);
          put_desc(32'hF00, sb, code, code, so, 32'(2 * n), 32'h40, 32'h600, 9'(ci), dof,
                   32'hFFFF_FFF0, 9'(ci), 1'b0, 1'b0, ci_sel == 1);
          model(sb, code, so, 32'(2 * n), 32'h40, 32'h600, ci, dof, 32'hFFFF_FFF0, 1'b1, fs, fd);
          kick(32'hF00);
          wait_idle();
          chk("R2 first fetch address", first_req_addr, 32'hF00);
          cmp_mem("R3 R5 memory image");
          chk("R4 R6 source address", src_addr, fs);
          chk("R4 R6 destination address", dst_addr, fd);
          chk("R10 done after run", {31'd0, done}, 32'd1);
          chk("R8 end interrupt count", 32'(irq_cnt), 32'(ci_sel));
          chk("R12 no error code", {29'd0, err_code}, 32'd0);
        end
    lat = 1;

    // halfway interrupt
    fill(3);
    put_desc(32'hF00, 32'h100, 3'd2, 3'd2, 16'd4, 32'd8, 32'd0, 32'h600, 9'd4, 16'd4,
             32'd0, 9'd4, 1'b0, 1'b1, 1'b1);
    model(32'h100, 3'd2, 16'd4, 32'd8, 32'd0, 32'h600, 4, 16'd4, 32'd0, 1'b1, fs, fd);
    kick(32'hF00); wait_idle();
    chk("R9 halfway plus end interrupts", 32'(irq_cnt), 32'd2);
    cmp_mem("R9 memory with halfway interrupt");

    // linked pair, both requesting the end interrupt
    for (int first_irq = 1; first_irq >= 0; first_irq--) begin
      fill(40 + first_irq);
      put_desc(32'hF00, 32'h100, 3'd2, 3'd2, 16'd4, 32'd8, 32'h77, 32'h600, 9'd1, 16'd4,
               32'hF40, 9'd1, 1'b1, 1'b0, first_irq == 1);
      put_desc(32'hF40, 32'h200, 3'd0, 3'd0, 16'd1, 32'd3, 32'h10, 32'h700, 9'd2, 16'd1,
               32'h20, 9'd2, 1'b0, 1'b0, 1'b1);
      model(32'h100, 3'd2, 16'd4, 32'd8, 32'h77, 32'h600, 1, 16'd4, 32'hF40, 1'b0, fs, fd);
      model(32'h200, 3'd0, 16'd1, 32'd3, 32'h10, 32'h700, 2, 16'd1, 32'h20, 1'b1, fs2, fd2);
      kick(32'hF00); wait_idle();
      cmp_mem("R7 chained memory image");
      chk("R7 chained source address", src_addr, fs2);
      chk("R7 chained destination address", dst_addr, fd2);
      chk("R8 chained interrupt count", 32'(irq_cnt), 32'(1 + first_irq));
      chk("R10 chained done", {31'd0, done}, 32'd1);
    end

    // descriptors that must be refused
    for (int k = 0; k < 5; k++) begin
      logic [2:0] sc, dc;
      logic [31:0] nb;
      logic [8:0] ci;
      sc = 3'd2; dc = 3'd2; nb = 32'd8; ci = 9'd1;
      case (k)
        0: nb = 32'd0;
        1: begin sc = 3'd3; dc = 3'd3; end
        2: dc = 3'd1;
        3: nb = 32'd6;
        default: ci = 9'd0;
      endcase
      fill(60 + k);
      put_desc(32'hF00, 32'h100, sc, dc, 16'd4, nb, 32'd0, 32'h600, ci, 16'd4, 32'd0, 9'd1,
               1'b0, 1'b0, 1'b1);
      kick(32'hF00); wait_idle();
      chk("R11 error code", {29'd0, err_code}, 32'd1);
      chk("R11 only descriptor reads", 32'(xact), 32'd8);
      cmp_mem("R11 memory untouched");
      chk("R10 done cleared by start", {30'd0, done, busy}, 32'd0);
    end

    // memory error responses
    for (int k = 0; k < 3; k++) begin
      int cnt_at;
      fill(80 + k);
      put_desc(32'hF00, 32'h100, 3'd2, 3'd2, 16'd4, 32'd8, 32'd0, 32'h600, 9'd2, 16'd4,
               32'd0, 9'd2, 1'b0, 1'b0, 1'b1);
      inj_en = 1'b1;
      inj_we = (k == 1);
      inj_addr = (k == 0) ? 32'h104 : (k == 1) ? 32'h604 : 32'hF0C;
      if (k == 0 || k == 1) model(32'h100, 3'd2, 16'd4, 32'd4, 32'd0, 32'h600, 1, 16'd4, 32'd0, 1'b0, fs, fd);
      kick(32'hF00); wait_idle();
      cnt_at = xact;
      repeat (10) @(negedge clk);
      chk("R12 abort reason", {29'd0, err_code}, (k == 0) ? 32'd2 : (k == 1) ? 32'd3 : 32'd4);
      chk("R12 transactions until abort", 32'(cnt_at), (k == 0) ? 32'd11 : (k == 1) ? 32'd12 : 32'd4);
      chk("R12 silent after abort", 32'(xact), 32'(cnt_at));
      chk("R12 done stays low", {31'd0, done}, 32'd0);
      cmp_mem("R12 memory after abort");
      inj_en = 1'b0;
    end

    // start while busy
    fill(99);
    put_desc(32'hF00, 32'h100, 3'd0, 3'd0, 16'd1, 32'd16, 32'd0, 32'h600, 9'd1, 16'd1,
             32'd0, 9'd1, 1'b0, 1'b0, 1'b1);
    put_desc(32'hF80, 32'h300, 3'd2, 3'd2, 16'd4, 32'd4, 32'd0, 32'h900, 9'd1, 16'd4,
             32'd0, 9'd1, 1'b0, 1'b0, 1'b1);
    model(32'h100, 3'd0, 16'd1, 32'd16, 32'd0, 32'h600, 1, 16'd1, 32'd0, 1'b1, fs, fd);
    kick(32'hF00);
    repeat (30) @(negedge clk);
    desc_addr = 32'hF80; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    cmp_mem("R13 second start ignored");
    chk("R13 single interrupt", 32'(irq_cnt), 32'd1);
    chk("R13 first run addresses", dst_addr, fd);

    chk("R14 request held until response", 32'(hold_viol), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule